// File: doc/BRIEF.md
# Indexed Display-Mode Register Port

This block is the register file behind a display adapter's extended-mode control. Software reaches it through two strobed ports. A strobe on the index port loads a register number. A strobe on the data port then reads or writes whichever register that number selects. Index and data share one 16-bit write bus, and read data comes back through a registered output.

The block holds the following:
- the ordinary mode registers, including an identification word and an enable word;
- a read-only word giving the video memory size in 64 KiB units;
- a read-only extended-capability word;
- a framebuffer byte-order control bit. This bit sits outside the ordinary register array, and its reset value comes from a platform strap pin.

The block drives the current byte order, the low byte of the enable word and a bank mask derived from the memory size to the rest of the adapter. A fixed bit in the enable word tells software that the extended-capability word exists.

Top module: `dispmode_regport`

## Requirements
- R1: After reset the index is 0, and a data read with no index write returns the identification value 0xB0C5. The enable word reads 0x0010 and all other mode registers (indices 1 to 9) read 0. The read-data output is 0, `enable_flags_o` is 0x10, `big_endian_o` equals `endian_strap`, and `bank_mask_o` equals (VRAM_BYTES >> 16) − 1.
- R2: An index-port strobe only changes the selected register number. It leaves every stored register and the byte-order bit unchanged.
- R3: A data write to indices 0 to 9, other than 4, stores all 16 bits of the write bus. A later read of that index returns them.
- R4: A data write to index 4 (the enable word) stores the written value with bit 4 (0x10) forced to 1. `enable_flags_o` then shows the low byte of the stored word. Bit meanings are: bit 0 enabled, bit 1 capability query, bit 5 8-bit palette, bit 6 linear framebuffer, bit 7 keep memory.
- R5: Index 0x0A reads VRAM_BYTES / 65536, which is 0x0080 with the default parameters. A write to index 0x0A changes nothing.
- R6: Index 0x0B reads 0x0001, where bit 0 announces the byte-order register. Writes to it are ignored.
- R7: A data write to index 0x0C stores bit 0 of the write bus as the byte-order bit (1 = big-endian) and drives it on `big_endian_o` from the next cycle. A read of index 0x0C returns 0x0001 or 0x0000.
- R8: Any index of 0x0D or above reads 0, and writes to such an index change no register.
- R9: Read data appears on `rdata` in the cycle after the `data_rd` strobe and holds until the next `data_rd` strobe.
- R10: When a data read and a data write fall in the same cycle, the read returns the value held before the write. When an index strobe and a data write fall in the same cycle, the write goes to the previously selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| endian_strap | input | 1 | Reset value of the byte-order bit (1 = big-endian) |
| idx_wr | input | 1 | Strobe that loads `wdata` into the index |
| data_wr | input | 1 | Strobe that writes `wdata` to the selected register |
| data_rd | input | 1 | Strobe that reads the selected register into `rdata` |
| wdata | input | 16 | Shared write bus for index and data |
| rdata | output | 16 | Registered read data |
| big_endian_o | output | 1 | Current framebuffer byte order |
| enable_flags_o | output | 8 | Low byte of the enable word |
| bank_mask_o | output | 16 | Bank mask set at reset from the memory size |

## Verification
Two pairs of functions can land in the same clock cycle:
- A data read can coincide with a data write to the same register.
- An index load can coincide with a data write, because both take their value from the one shared write bus.

The bench provokes the first pair by raising `data_rd` and `data_wr` together on a register with a known value. It expects the old value on `rdata`, and the new value on a second read. It provokes the second pair by raising `idx_wr` and `data_wr` together with the value 0x000C while index 3 is selected. It then checks three things: register 3 now holds 0x000C, the index points at the byte-order register, and the byte-order bit kept its previous value.

// File: rtl/dm_pkg.sv
package dm_pkg;

  localparam logic [15:0] IDX_MEMSIZE = 16'h000A;
  localparam logic [15:0] IDX_XCAPS   = 16'h000B;
  localparam logic [15:0] IDX_BORDER  = 16'h000C;
  localparam int          IDX_ENABLE  = 4;
  localparam logic [15:0] ID_RESET    = 16'hB0C5;
  localparam logic [15:0] ENA_XCAP    = 16'h0010;
  localparam logic [15:0] XCAPS_VALUE = 16'h0001;

  function automatic logic [15:0] enable_store(input logic [15:0] v);
    return v | ENA_XCAP;
  endfunction

  function automatic logic [15:0] mem_units(input longint bytes);
    return 16'(bytes >> 16);
  endfunction

  function automatic logic [15:0] bank_mask_of(input longint bytes);
    return 16'((bytes >> 16) - 1);
  endfunction

  function automatic logic [15:0] border_word(input logic be);
    return {15'd0, be};
  endfunction

  function automatic logic [15:0] reg_reset_value(input int n);
    if (n == 0)          return ID_RESET;
    if (n == IDX_ENABLE) return ENA_XCAP;
    return 16'h0000;
  endfunction

endpackage

// File: rtl/dm_index_reg.sv
module dm_index_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/dm_mode_bank.sv
module dm_mode_bank
  import dm_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 10,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [W-1:0]    din,
  input  logic [SELW-1:0] rd_sel,
  output logic [W-1:0]    rd_val,
  output logic [W-1:0]    enable_q
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SELW'(g));
    if (g == IDX_ENABLE) begin : g_ena
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[g] <= W'(reg_reset_value(g));
        else if (hit) regs[g] <= W'(enable_store(16'(din)));
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[g] <= W'(reg_reset_value(g));
        else if (hit) regs[g] <= din;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_sel == SELW'(k)) rd_val = regs[k];
  end

  assign enable_q = regs[IDX_ENABLE];
endmodule

// File: rtl/dm_border_ctl.sv
module dm_border_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic wr_en,
  input  logic din,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= strap;
    else if (wr_en) q <= din;
  end
endmodule

// File: rtl/dispmode_regport.sv
module dispmode_regport
  import dm_pkg::*;
#(
  parameter longint VRAM_BYTES = 64'd8388608,
  parameter int     NREG       = 10,
  localparam int    W          = 16,
  localparam int    SELW       = $clog2(NREG)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         endian_strap,
  input  logic         idx_wr,
  input  logic         data_wr,
  input  logic         data_rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         big_endian_o,
  output logic [7:0]   enable_flags_o,
  output logic [W-1:0] bank_mask_o
);
  logic [W-1:0] cur_idx;
  logic [W-1:0] bank_val;
  logic [W-1:0] enable_word;
  logic [W-1:0] rd_mux;

  // Named decode events, also seen by the checker
  logic hit_bank, hit_memsize, hit_xcaps, hit_border;
  logic bank_write, border_write;

  assign hit_bank     = cur_idx < W'(NREG);
  assign hit_memsize  = cur_idx == IDX_MEMSIZE;
  assign hit_xcaps    = cur_idx == IDX_XCAPS;
  assign hit_border   = cur_idx == IDX_BORDER;
  assign bank_write   = data_wr && hit_bank;
  assign border_write = data_wr && hit_border;

  dm_index_reg #(.W(W)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_wr), .din(wdata), .q(cur_idx)
  );

  dm_mode_bank #(.W(W), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_write),
    .wr_sel(cur_idx[SELW-1:0]), .din(wdata),
    .rd_sel(cur_idx[SELW-1:0]), .rd_val(bank_val), .enable_q(enable_word)
  );

  dm_border_ctl u_border (
    .clk(clk), .rst_n(rst_n), .strap(endian_strap),
    .wr_en(border_write), .din(wdata[0]), .q(big_endian_o)
  );

  always_comb begin
    if (hit_bank)         rd_mux = bank_val;
    else if (hit_memsize) rd_mux = mem_units(VRAM_BYTES);
    else if (hit_xcaps)   rd_mux = XCAPS_VALUE;
    else if (hit_border)  rd_mux = border_word(big_endian_o);
    else                  rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (data_rd) rdata <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_mask_o <= bank_mask_of(VRAM_BYTES);
  end

  assign enable_flags_o = enable_word[7:0];
endmodule

// File: rtl/dm_checker.sv
module dm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        data_wr,
  input logic        data_rd,
  input logic [15:0] wdata,
  input logic [15:0] cur_idx,
  input logic [15:0] rdata,
  input logic        big_endian_o,
  input logic [7:0]  enable_flags_o,
  input logic [15:0] bank_mask_o
);
  p_enable_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_idx == 16'h0004) |=> enable_flags_o == ($past(wdata[7:0]) | 8'h10));

  p_border_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_idx == 16'h000C) |=> big_endian_o == $past(wdata[0]));

  p_border_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && cur_idx == 16'h000C) |=> $stable(big_endian_o));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(rdata));

  p_xcaps_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && cur_idx == 16'h000B) |=> rdata == 16'h0001);

  p_undef_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && cur_idx > 16'h000C) |=> rdata == 16'h0000);

  p_bank_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bank_mask_o));
endmodule

bind dispmode_regport dm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_rd(data_rd),
  .wdata(wdata), .cur_idx(cur_idx), .rdata(rdata),
  .big_endian_o(big_endian_o), .enable_flags_o(enable_flags_o),
  .bank_mask_o(bank_mask_o)
);

// File: tb/sim_dispmode_regport.sv
module sim_dispmode_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        endian_strap = 1'b0;
  logic        idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, bank_mask_o;
  logic        big_endian_o;
  logic [7:0]  enable_flags_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] got;

  always #2 clk = ~clk;

  dispmode_regport u0 (.*);

  // {index, do_write, write value, expected read}
  localparam int NV = 14;
  localparam logic [48:0] VEC [NV] = '{
    {16'h0001, 1'b1, 16'h0280, 16'h0280},  // R3
    {16'h0002, 1'b1, 16'h01E0, 16'h01E0},  // R3
    {16'h0003, 1'b1, 16'h0020, 16'h0020},  // R3
    {16'h0004, 1'b1, 16'h0041, 16'h0051},  // R4
    {16'h0004, 1'b1, 16'h00E3, 16'h00F3},  // R4
    {16'h0009, 1'b1, 16'hBEEF, 16'hBEEF},  // R3
    {16'h0000, 1'b1, 16'hB0C4, 16'hB0C4},  // R3
    {16'h000A, 1'b1, 16'h1234, 16'h0080},  // R5
    {16'h000B, 1'b1, 16'hFFFF, 16'h0001},  // R6
    {16'h000C, 1'b1, 16'h0003, 16'h0001},  // R7
    {16'h000C, 1'b1, 16'hFFFE, 16'h0000},  // R7
    {16'h000D, 1'b1, 16'h5555, 16'h0000},  // R8
    {16'hFFFF, 1'b1, 16'h0001, 16'h0000},  // R8
    {16'h0001, 1'b0, 16'h0000, 16'h0280}   // R2 R8
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [15:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic put(input logic [15:0] v);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic get(output logic [15:0] v);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0; v = rdata;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst_n = 1'b0; endian_strap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    check("R1 rdata", rdata, 16'h0000);
    check("R1 enable_flags", {8'h00, enable_flags_o}, 16'h0010);
    check("R1 big_endian", {15'd0, big_endian_o}, 16'h0000);
    check("R1 bank_mask", bank_mask_o, 16'h007F);
    get(got); check("R1 id at index 0", got, 16'hB0C5);
    set_idx(16'h0004); get(got); check("R1 enable word", got, 16'h0010);
    set_idx(16'h0005); get(got); check("R1 reg5 zero", got, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      set_idx(VEC[i][48:33]);
      if (VEC[i][32]) put(VEC[i][31:16]);
      get(got);
      check($sformatf("vector %0d (R3..R8)", i), got, VEC[i][15:0]);
      if (i == 4) check("R4 enable_flags", {8'h00, enable_flags_o}, 16'h00F3);
      if (i == 9) check("R7 big_endian set", {15'd0, big_endian_o}, 16'h0001);
      if (i == 10) check("R7 big_endian clear", {15'd0, big_endian_o}, 16'h0000);
    end

    // R2: index strobes alone leave content intact
    set_idx(16'h0009); set_idx(16'h0002); set_idx(16'h0009);
    get(got); check("R2 reg9 intact", got, 16'hBEEF);

    // R9: rdata holds without a read strobe
    set_idx(16'h000B);
    repeat (2) @(negedge clk);
    check("R9 rdata hold", rdata, 16'hBEEF);

    // R10: read and write same cycle
    set_idx(16'h0002);
    @(negedge clk); data_rd = 1'b1; data_wr = 1'b1; wdata = 16'h7777;
    @(negedge clk); data_rd = 1'b0; data_wr = 1'b0;
    check("R10 read old value", rdata, 16'h01E0);
    get(got); check("R10 new value", got, 16'h7777);

    // R10: index and data write same cycle
    set_idx(16'h0003);
    @(negedge clk); idx_wr = 1'b1; data_wr = 1'b1; wdata = 16'h000C;
    @(negedge clk); idx_wr = 1'b0; data_wr = 1'b0;
    get(got); check("R10 index moved, border kept", got, 16'h0000);
    check("R10 big_endian kept", {15'd0, big_endian_o}, 16'h0000);
    set_idx(16'h0003); get(got); check("R10 write hit old index", got, 16'h000C);

    // R1: strap drives reset byte order
    do_reset(1'b1);
    @(negedge clk);
    check("R1 strap big_endian", {15'd0, big_endian_o}, 16'h0001);
    set_idx(16'h000C); get(got); check("R1 strap border read", got, 16'h0001);
    set_idx(16'h0009); get(got); check("R1 reg9 cleared", got, 16'h0000);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule